// File: doc/BRIEF.md
# Version-Switchable Two-Level LUT Network

This block models a small logic cone built from look-up tables whose stored contents can be re-encoded while the circuit runs. Four first-level 4-input tables each feed one select input of a single second-level 4-input table. A 4-bit active version chooses which of those four links carries its signal complemented. Complementing a link is done by inverting every stored bit of the driving first-level table. The second-level table cancels that inversion by reordering its own stored bits with an XOR on the address. The result is that the network computes the same function under every version, while the physical memory cells that a given input pattern reads are different.

Stepping through versions during normal operation makes cells that the normal input range never reaches get read anyway, so faults hidden in them can show up before they matter. Software loads the unmodified ("logical") table contents and a circular list of up to 16 versions. A strobe then advances through the list one entry at a time, or a direct load sets a version at once. A second-level input that is wired straight to a primary input cannot be complemented. The parameter `INV_MASK` marks which inputs are invertible, and version bits at the other positions are always forced to 0.

Top module: `lut_version_net`

## Requirements
- R1: While rst_ni is low, y_o, phys_addr_o, active_ver_o, phys_mask_o and all stored logical tables and list entries are 0.
- R2: First-level table k (k=0 feeds second-level input A, 1 feeds B, 2 feeds C, 3 feeds D) is addressed by lut_in_i[4k+3:4k]. The second-level logical address is {D,C,B,A}, with D as the most significant bit. An input position whose INV_MASK bit is 0 is driven by direct_i[k] instead of a table.
- R3: phys_mask_o[16k+15:16k] equals logical table k XORed with 16 copies of active_ver_o[k].
- R4: phys_mask_o[79:64] bit a equals logical second-level table bit (a XOR active_ver_o).
- R5: y_o equals the logical network function of the inputs present at the previous rising clock edge, for every active version.
- R6: phys_addr_o equals the logical second-level address at the previous edge XOR the version active at that edge.
- R7: active_ver_o bits at positions where INV_MASK is 0 are always 0. Any requested version is ANDed with INV_MASK (default 4'b1011, so input C is not invertible).
- R8: ver_set_i loads ver_i & INV_MASK into active_ver_o at the next edge. It takes priority over adv_i, and the list pointer does not move in that cycle.
- R9: Each adv_i edge moves the list pointer to the next index, wrapping from list_last_i to 0, and loads that list entry. Entries are written with list_we_i/list_idx_i/list_ver_i and stored masked.
- R10: Without ver_set_i or adv_i, active_ver_o holds its value, including across table loads.
- R11: With load_en_i high, load_sel_i 0..3 writes first-level table k and load_sel_i 4 writes the second-level table. Values 5..7 change nothing.
- R12: Under version x XOR y, the physical second-level cells at addresses x and y hold each other's logical bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lut_in_i | input | 16 | First-level table addresses, 4 bits per table |
| direct_i | input | 4 | Direct drive for non-invertible second-level inputs |
| load_en_i | input | 1 | Table write enable |
| load_sel_i | input | 3 | Table select (0..3 first level, 4 second level) |
| load_data_i | input | 16 | Logical table contents |
| list_we_i | input | 1 | Version list write enable |
| list_idx_i | input | 4 | Version list write index |
| list_ver_i | input | 4 | Version list write value |
| list_last_i | input | 4 | Index of last list entry before wrap |
| ver_set_i | input | 1 | Direct version load strobe |
| ver_i | input | 4 | Version for direct load |
| adv_i | input | 1 | Advance-to-next-version strobe |
| y_o | output | 1 | Registered network output |
| phys_addr_o | output | 4 | Registered physical second-level address |
| active_ver_o | output | 4 | Active version |
| phys_mask_o | output | 80 | Physical contents, table k at [16k+15:16k], second level at [79:64] |

## Verification
A wrong active version, or a transform that is out of step with the version, shows on y_o one cycle later. It only shows for input patterns whose logical address reaches a cell the wrong transform moved, so the bench sweeps many inputs under every allowed version. Such a fault also appears at once on phys_mask_o, and on phys_addr_o one edge later. A pointer or priority fault in the version sequencer shows on active_ver_o at the edge after the strobe.

// File: rtl/lvn_pkg.sv
package lvn_pkg;
  localparam int unsigned LVN_K          = 4;
  localparam int unsigned LVN_LIST_DEPTH = 16;

  typedef enum logic [1:0] {
    VCMD_HOLD = 2'd0,
    VCMD_ADV  = 2'd1,
    VCMD_SET  = 2'd2
  } vcmd_e;
endpackage

// File: rtl/lvn_version_ctrl.sv
module lvn_version_ctrl
  import lvn_pkg::*;
#(
  parameter int unsigned K          = LVN_K,
  parameter int unsigned LIST_DEPTH = LVN_LIST_DEPTH,
  parameter logic [K-1:0] INV_MASK  = '1,
  localparam int unsigned IDX_W     = $clog2(LIST_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             list_we_i,
  input  logic [IDX_W-1:0] list_idx_i,
  input  logic [K-1:0]     list_ver_i,
  input  logic [IDX_W-1:0] list_last_i,
  input  logic             ver_set_i,
  input  logic [K-1:0]     ver_i,
  input  logic             adv_i,
  output logic [K-1:0]     active_ver_o
);
  logic [LIST_DEPTH-1:0][K-1:0] list_q;
  logic [IDX_W-1:0]             ptr_q, ptr_nxt;
  logic [K-1:0]                 ver_q;
  vcmd_e                        cmd;

  always_comb begin
    if (ver_set_i)  cmd = VCMD_SET;
    else if (adv_i) cmd = VCMD_ADV;
    else            cmd = VCMD_HOLD;
    ptr_nxt = (ptr_q == list_last_i) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      list_q <= '0;
    end else if (list_we_i) begin
      list_q[list_idx_i] <= list_ver_i & INV_MASK;
    end
  end

  // version changes only at the edge that samples a strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      ver_q <= '0;
    end else begin
      case (cmd)
        VCMD_SET: ver_q <= ver_i & INV_MASK;
        VCMD_ADV: begin
          ptr_q <= ptr_nxt;
          ver_q <= list_q[ptr_nxt];
        end
        default: ;
      endcase
    end
  end

  assign active_ver_o = ver_q;
endmodule

// File: rtl/lvn_mask_xform.sv
module lvn_mask_xform
  import lvn_pkg::*;
#(
  parameter int unsigned K         = LVN_K,
  parameter logic [K-1:0] INV_MASK = '1,
  localparam int unsigned MASK_W   = 1 << K
) (
  input  logic [K-1:0][MASK_W-1:0] mask1_i,
  input  logic [MASK_W-1:0]        mask2_i,
  input  logic [K-1:0]             ver_i,
  output logic [K-1:0][MASK_W-1:0] phys1_o,
  output logic [MASK_W-1:0]        phys2_o
);
  for (genvar k = 0; k < K; k++) begin : g_first
    if (INV_MASK[k]) begin : g_inv
      assign phys1_o[k] = mask1_i[k] ^ {MASK_W{ver_i[k]}};
    end else begin : g_fixed
      assign phys1_o[k] = mask1_i[k];
    end
  end

  // cell a holds logical bit a^v, cancelling the inverted selects
  for (genvar a = 0; a < MASK_W; a++) begin : g_perm
    assign phys2_o[a] = mask2_i[K'(a) ^ ver_i];
  end
endmodule

// File: rtl/lvn_eval.sv
module lvn_eval
  import lvn_pkg::*;
#(
  parameter int unsigned K         = LVN_K,
  parameter logic [K-1:0] INV_MASK = '1,
  localparam int unsigned MASK_W   = 1 << K
) (
  input  logic [K*K-1:0]           lut_in_i,
  input  logic [K-1:0]             direct_i,
  input  logic [K-1:0][MASK_W-1:0] phys1_i,
  input  logic [MASK_W-1:0]        phys2_i,
  output logic [K-1:0]             phys_addr_o,
  output logic                     y_o
);
  for (genvar k = 0; k < K; k++) begin : g_sel
    if (INV_MASK[k]) begin : g_lut
      assign phys_addr_o[k] = phys1_i[k][lut_in_i[k*K +: K]];
    end else begin : g_direct
      assign phys_addr_o[k] = direct_i[k];
    end
  end

  assign y_o = phys2_i[phys_addr_o];
endmodule

// File: rtl/lut_version_net.sv
module lut_version_net
  import lvn_pkg::*;
#(
  parameter int unsigned K          = LVN_K,
  parameter int unsigned LIST_DEPTH = LVN_LIST_DEPTH,
  parameter logic [K-1:0] INV_MASK  = 4'b1011,
  localparam int unsigned MASK_W    = 1 << K,
  localparam int unsigned IDX_W     = $clog2(LIST_DEPTH),
  localparam int unsigned SEL_W     = $clog2(K + 1),
  localparam int unsigned K_W       = (K > 1) ? $clog2(K) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [K*K-1:0]           lut_in_i,
  input  logic [K-1:0]             direct_i,
  input  logic                     load_en_i,
  input  logic [SEL_W-1:0]         load_sel_i,
  input  logic [MASK_W-1:0]        load_data_i,
  input  logic                     list_we_i,
  input  logic [IDX_W-1:0]         list_idx_i,
  input  logic [K-1:0]             list_ver_i,
  input  logic [IDX_W-1:0]         list_last_i,
  input  logic                     ver_set_i,
  input  logic [K-1:0]             ver_i,
  input  logic                     adv_i,
  output logic                     y_o,
  output logic [K-1:0]             phys_addr_o,
  output logic [K-1:0]             active_ver_o,
  output logic [(K+1)*MASK_W-1:0]  phys_mask_o
);
  logic [K-1:0][MASK_W-1:0] mask1_q, phys1;
  logic [MASK_W-1:0]        mask2_q, phys2;
  logic [K-1:0]             ver, paddr;
  logic                     y_comb, y_q;
  logic [K-1:0]             paddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask1_q <= '0;
      mask2_q <= '0;
    end else if (load_en_i) begin
      if (load_sel_i < SEL_W'(K))       mask1_q[load_sel_i[K_W-1:0]] <= load_data_i;
      else if (load_sel_i == SEL_W'(K)) mask2_q <= load_data_i;
    end
  end

  lvn_version_ctrl #(.K(K), .LIST_DEPTH(LIST_DEPTH), .INV_MASK(INV_MASK)) u_vctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .list_we_i   (list_we_i),
    .list_idx_i  (list_idx_i),
    .list_ver_i  (list_ver_i),
    .list_last_i (list_last_i),
    .ver_set_i   (ver_set_i),
    .ver_i       (ver_i),
    .adv_i       (adv_i),
    .active_ver_o(ver)
  );

  lvn_mask_xform #(.K(K), .INV_MASK(INV_MASK)) u_xform (
    .mask1_i(mask1_q),
    .mask2_i(mask2_q),
    .ver_i  (ver),
    .phys1_o(phys1),
    .phys2_o(phys2)
  );

  lvn_eval #(.K(K), .INV_MASK(INV_MASK)) u_eval (
    .lut_in_i   (lut_in_i),
    .direct_i   (direct_i),
    .phys1_i    (phys1),
    .phys2_i    (phys2),
    .phys_addr_o(paddr),
    .y_o        (y_comb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q     <= 1'b0;
      paddr_q <= '0;
    end else begin
      y_q     <= y_comb;
      paddr_q <= paddr;
    end
  end

  for (genvar k = 0; k < K; k++) begin : g_pm
    assign phys_mask_o[k*MASK_W +: MASK_W] = phys1[k];
  end
  assign phys_mask_o[K*MASK_W +: MASK_W] = phys2;

  assign y_o          = y_q;
  assign phys_addr_o  = paddr_q;
  assign active_ver_o = ver;
endmodule

// File: rtl/lvn_checker.sv
module lvn_checker
  import lvn_pkg::*;
#(
  parameter int unsigned K         = LVN_K,
  parameter logic [K-1:0] INV_MASK = '1,
  localparam int unsigned MASK_W   = 1 << K
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [K*K-1:0]           lut_in_i,
  input logic [K-1:0]             direct_i,
  input logic                     ver_set_i,
  input logic [K-1:0]             ver_i,
  input logic                     adv_i,
  input logic                     y_o,
  input logic [K-1:0]             phys_addr_o,
  input logic [K-1:0]             active_ver_o,
  input logic [MASK_W-1:0]        phys2_i,
  input logic [K-1:0][MASK_W-1:0] mask1_q,
  input logic [MASK_W-1:0]        mask2_q
);
  logic [K-1:0] log_addr;
  logic         log_y;
  logic         seen_q;

  always_comb begin
    for (int k = 0; k < K; k++) begin
      log_addr[k] = INV_MASK[k] ? mask1_q[k][lut_in_i[k*K +: K]] : direct_i[k];
    end
    log_y = mask2_q[log_addr];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_out_invariant_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (y_o == $past(log_y)));

  p_addr_xor_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (phys_addr_o == ($past(log_addr) ^ $past(active_ver_o))));

  p_ver_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_ver_o & ~INV_MASK) == '0);

  p_ver_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ver_set_i |=> (active_ver_o == ($past(ver_i) & INV_MASK)));

  p_ver_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ver_set_i && !adv_i) |=> $stable(active_ver_o));

  p_perm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys2_i[0] == mask2_q[active_ver_o]);
endmodule

bind lut_version_net lvn_checker #(.K(K), .INV_MASK(INV_MASK)) u_lvn_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lut_in_i    (lut_in_i),
  .direct_i    (direct_i),
  .ver_set_i   (ver_set_i),
  .ver_i       (ver_i),
  .adv_i       (adv_i),
  .y_o         (y_o),
  .phys_addr_o (phys_addr_o),
  .active_ver_o(active_ver_o),
  .phys2_i     (phys_mask_o[K*MASK_W +: MASK_W]),
  .mask1_q     (mask1_q),
  .mask2_q     (mask2_q)
);

// File: tb/lut_version_net_bench.sv
`timescale 1ns/1ps
module lut_version_net_bench;
  localparam logic [3:0] INV = 4'b1011;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] lut_in_i = '0;
  logic [3:0]  direct_i = '0;
  logic        load_en_i = 1'b0;
  logic [2:0]  load_sel_i = '0;
  logic [15:0] load_data_i = '0;
  logic        list_we_i = 1'b0;
  logic [3:0]  list_idx_i = '0;
  logic [3:0]  list_ver_i = '0;
  logic [3:0]  list_last_i = '0;
  logic        ver_set_i = 1'b0;
  logic [3:0]  ver_i = '0;
  logic        adv_i = 1'b0;
  logic        y_o;
  logic [3:0]  phys_addr_o;
  logic [3:0]  active_ver_o;
  logic [79:0] phys_mask_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m1 [4];
  logic [15:0] m2;

  always #5 clk_i = ~clk_i;

  lut_version_net #(.INV_MASK(INV)) u_lut_version_net (.*);

  // stimulus: {version[23:20], lut_in[19:4], direct[3:0]}
  localparam logic [23:0] TBL [12] = '{
    24'h0_0000_0, 24'h0_FFFF_F, 24'h1_1234_5, 24'h2_ABCD_4,
    24'h3_5A5A_0, 24'h8_0F0F_F, 24'h9_F00F_4, 24'hA_3C3C_B,
    24'hB_8421_7, 24'hB_7BDE_0, 24'hF_C0DE_4, 24'h4_BEEF_F
  };

  function automatic logic [3:0] ref_addr(logic [15:0] li, logic [3:0] d);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) r[k] = INV[k] ? m1[k][li[k*4 +: 4]] : d[k];
    return r;
  endfunction

  function automatic logic [15:0] ref_perm(logic [15:0] m, logic [3:0] v);
    logic [15:0] r;
    for (int a = 0; a < 16; a++) r[a] = m[4'(a) ^ v];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic load(input logic [2:0] sel, input logic [15:0] d);
    load_en_i = 1'b1; load_sel_i = sel; load_data_i = d;
    tick();
    load_en_i = 1'b0;
  endtask

  task automatic set_ver(input logic [3:0] v);
    ver_set_i = 1'b1; ver_i = v;
    tick();
    ver_set_i = 1'b0;
  endtask

  task automatic adv();
    adv_i = 1'b1;
    tick();
    adv_i = 1'b0;
  endtask

  task automatic wr_list(input logic [3:0] idx, input logic [3:0] v);
    list_we_i = 1'b1; list_idx_i = idx; list_ver_i = v;
    tick();
    list_we_i = 1'b0;
  endtask

  // applies one input pattern and checks output and physical address
  task automatic apply_chk(input logic [15:0] li, input logic [3:0] d, input string tag);
    logic [3:0] la, v;
    lut_in_i = li; direct_i = d;
    la = ref_addr(li, d);
    v = active_ver_o;
    tick();
    chk(y_o == m2[la], {tag, " R5 y"}, 80'(y_o), 80'(m2[la]));
    chk(phys_addr_o == (la ^ v), {tag, " R6 addr"}, 80'(phys_addr_o), 80'(la ^ v));
  endtask

  function automatic logic [79:0] exp_pm(logic [3:0] v);
    logic [79:0] r;
    for (int k = 0; k < 4; k++) r[k*16 +: 16] = m1[k] ^ {16{v[k] & INV[k]}};
    r[79:64] = ref_perm(m2, v & INV);
    return r;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    m1[0] = 16'h6996; m1[1] = 16'hFEEE; m1[2] = 16'h00FF; m1[3] = 16'h1E35;
    m2 = 16'hB4C7;

    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk(y_o == 1'b0, "R1 y", 80'(y_o), 80'd0);
    chk(active_ver_o == 4'd0, "R1 ver", 80'(active_ver_o), 80'd0);
    chk(phys_addr_o == 4'd0, "R1 addr", 80'(phys_addr_o), 80'd0);
    chk(phys_mask_o == 80'd0, "R1 masks", phys_mask_o, 80'd0);
    rst_ni = 1'b1;
    tick();

    // R11: table loads
    for (int k = 0; k < 4; k++) load(3'(k), m1[k]);
    load(3'd4, m2);
    chk(phys_mask_o == exp_pm(4'd0), "R11 load", phys_mask_o, exp_pm(4'd0));
    load(3'd5, 16'hFFFF);
    load(3'd7, 16'h0000);
    chk(phys_mask_o == exp_pm(4'd0), "R11 unused select", phys_mask_o, exp_pm(4'd0));
    chk(active_ver_o == 4'd0, "R10 load keeps version", 80'(active_ver_o), 80'd0);

    // R3 R4 R12: transform under version 4'b1010 (swaps cells 3 and 9)
    set_ver(4'b1010);
    chk(active_ver_o == 4'b1010, "R8 set", 80'(active_ver_o), 80'hA);
    chk(phys_mask_o[63:48] == ~m1[3], "R3 inverted D", 80'(phys_mask_o[63:48]), 80'(~m1[3]));
    chk(phys_mask_o[15:0] == m1[0], "R3 plain A", 80'(phys_mask_o[15:0]), 80'(m1[0]));
    chk(phys_mask_o[79:64] == ref_perm(m2, 4'b1010), "R4 permute", 80'(phys_mask_o[79:64]),
        80'(ref_perm(m2, 4'b1010)));
    chk(phys_mask_o[64+9] == m2[3] && phys_mask_o[64+3] == m2[9], "R12 swap",
        80'({phys_mask_o[64+9], phys_mask_o[64+3]}), 80'({m2[3], m2[9]}));

    // R7: non-invertible C masked, C follows direct_i
    set_ver(4'b1111);
    chk(active_ver_o == 4'b1011, "R7 masked", 80'(active_ver_o), 80'hB);
    chk(phys_mask_o == exp_pm(4'b1011), "R7 C table untouched", phys_mask_o, exp_pm(4'b1011));
    apply_chk(16'h1357, 4'b0000, "R7 C=0");
    chk(phys_addr_o[2] == 1'b0, "R7 C bit", 80'(phys_addr_o[2]), 80'd0);
    apply_chk(16'h1357, 4'b0100, "R7 C=1");
    chk(phys_addr_o[2] == 1'b1, "R7 C bit", 80'(phys_addr_o[2]), 80'd1);

    // R2 R5 R6: table of directed vectors
    foreach (TBL[i]) begin
      set_ver(TBL[i][23:20]);
      chk(active_ver_o == (TBL[i][23:20] & INV), "R8 table set", 80'(active_ver_o),
          80'(TBL[i][23:20] & INV));
      apply_chk(TBL[i][19:4], TBL[i][3:0], "R2 table");
    end

    // R9: circular list with wrap
    wr_list(4'd0, 4'h0); wr_list(4'd1, 4'h9); wr_list(4'd2, 4'hF);
    list_last_i = 4'd2;
    chk(active_ver_o == (TBL[11][23:20] & INV), "R10 list write holds", 80'(active_ver_o),
        80'(TBL[11][23:20] & INV));
    adv(); chk(active_ver_o == 4'h9, "R9 step1", 80'(active_ver_o), 80'h9);
    adv(); chk(active_ver_o == 4'hB, "R9 step2", 80'(active_ver_o), 80'hB);
    adv(); chk(active_ver_o == 4'h0, "R9 wrap", 80'(active_ver_o), 80'h0);

    // R8: set wins over advance, pointer stays at 0
    ver_set_i = 1'b1; ver_i = 4'b0011; adv_i = 1'b1;
    tick();
    ver_set_i = 1'b0; adv_i = 1'b0;
    chk(active_ver_o == 4'b0011, "R8 priority", 80'(active_ver_o), 80'h3);
    adv(); chk(active_ver_o == 4'h9, "R8 pointer kept", 80'(active_ver_o), 80'h9);

    // R10: hold over idle cycles with changing inputs
    for (int i = 0; i < 4; i++) apply_chk(16'(i * 16'h3F1D), 4'(i), "R10 idle");
    chk(active_ver_o == 4'h9, "R10 hold", 80'(active_ver_o), 80'h9);

    // R5 R6 R4: every allowed version over many inputs
    for (int i = 0; i < 8; i++) wr_list(4'(i), {i[2], 1'b0, i[1], i[0]});
    list_last_i = 4'd7;
    for (int s = 0; s < 8; s++) begin
      adv();
      chk(phys_mask_o == exp_pm(active_ver_o), "R4 sweep masks", phys_mask_o, exp_pm(active_ver_o));
      for (int i = 0; i < 64; i++)
        apply_chk(16'(i * 16'h9E37) ^ 16'(i << 7), 4'(i * 5), "R5 sweep");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule